// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Generator

This block derives three peripheral clocks from a single fast reference clock by counting reference cycles. One configuration word sets how many reference cycles make up one output period and how many of them the output stays high. Each of the three outputs can also be delayed by a quarter, a half or three quarters of the period. These outputs are the core clock, the clock that launches outgoing data and the clock that captures incoming data. Every phase shift is a whole number of reference cycles, because it is formed by comparing against a shifted counter position. No analog delay is used.

The configuration word is checked continuously. A word that is inconsistent raises an error flag and is never adopted. A consistent word takes effect only at the boundary between two output periods, so no output ever shows a truncated or stretched pulse in the middle of a period. All outputs are registered on the reference clock.

Top module: `clkgen_top`

## Requirements
- R1: While `rst` is high, all three clock outputs and `cfg_err` are low. The settings that apply after reset are a period of 4 reference cycles, a high time of 2 cycles and no phase shift on any output.
- R2: With period field P = `cfg_word[12:9]` and high field H = `cfg_word[16:13]`, the period is N = P+1 reference cycles and the high time is H+1 cycles. A position counter runs 0..N-1. After each reference edge, an output with shift s is high exactly when ((counter value before that edge) − s) mod N < H+1.
- R3: The field `cfg_word[20:17]` must equal the period field. If it does not, the word is flagged and ignored.
- R4: The 3-bit phase fields are `cfg_word[2:0]` for `clk_dout`, `cfg_word[5:3]` for `clk_din` and `cfg_word[8:6]` for `clk_core`. Code 0 selects quadrant 0, code 1 quadrant 1 (90°), code 4 quadrant 2 (180°) and code 6 quadrant 3 (270°).
- R5: The shift for quadrant q is round(N·q/4) cycles, with halves rounded upward, taken modulo N.
- R6: A word whose high field exceeds its period field is flagged and ignored, and the previous settings stay in force.
- R7: A phase code other than 0, 1, 4 or 6 in any of the three fields makes the word flagged and ignored.
- R8: `cfg_err` is high in the cycle after every reference edge at which `cfg_word` broke a rule of R3, R6 or R7, and low after every edge at which the word was valid.
- R9: A valid word is adopted only at the reference edge where the counter is at N−1 (the last cycle of a period). After that edge the counter restarts at 0 under the new settings. A word that is present only in mid-period has no effect.
- R10: When the high field equals the period field, an output stays high continuously. With P = 0 the output is high on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 21 | Configuration word: phases, period, high time, period copy |
| cfg_err | output | 1 | Registered flag, set when the sampled configuration word is invalid |
| clk_dout | output | 1 | Data-output clock |
| clk_din | output | 1 | Data-input clock |
| clk_core | output | 1 | Core clock |

## Verification
The hardest case to reach from the ports is a new word that arrives in mid-period, followed by a switch to a different period length. The new word must wait for the old period's last cycle, and the counter must then restart cleanly in the new length. The bench keeps its own model of the position counter and of the settings in force. It changes `cfg_word` right after a period boundary and checks every cycle that the old waveform continues until the model's wrap point. The same cycle-by-cycle model covers the odd periods whose quarter shifts round, and the invalid words that must leave the running waveform untouched.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

  localparam int PH_W = 3;

  localparam logic [PH_W-1:0] PH_Q0 = 3'd0;
  localparam logic [PH_W-1:0] PH_Q1 = 3'd1;
  localparam logic [PH_W-1:0] PH_Q2 = 3'd4;
  localparam logic [PH_W-1:0] PH_Q3 = 3'd6;

  function automatic logic phase_code_ok(input logic [PH_W-1:0] code);
    return (code == PH_Q0) || (code == PH_Q1) || (code == PH_Q2) || (code == PH_Q3);
  endfunction

  function automatic logic [1:0] phase_quadrant(input logic [PH_W-1:0] code);
    logic [1:0] q;
    case (code)
      PH_Q1:   q = 2'd1;
      PH_Q2:   q = 2'd2;
      PH_Q3:   q = 2'd3;
      default: q = 2'd0;
    endcase
    return q;
  endfunction

endpackage

// File: rtl/clkgen_cfg_check.sv
module clkgen_cfg_check
  import clkgen_pkg::*;
#(
  parameter int FW   = 4,
  parameter int NOUT = 3
) (
  input  logic [NOUT*PH_W+3*FW-1:0] cfg_i,
  output logic                      ok_o
);
  localparam int PER_LSB = NOUT*PH_W;
  localparam int HI_LSB  = PER_LSB + FW;
  localparam int MIR_LSB = HI_LSB + FW;

  logic [NOUT-1:0] code_ok;
  logic [FW-1:0]   per, hi, mir;

  assign per = cfg_i[PER_LSB +: FW];
  assign hi  = cfg_i[HI_LSB  +: FW];
  assign mir = cfg_i[MIR_LSB +: FW];

  for (genvar i = 0; i < NOUT; i++) begin : g_code
    assign code_ok[i] = phase_code_ok(cfg_i[i*PH_W +: PH_W]);
  end

  assign ok_o = (&code_ok) && (hi <= per) && (mir == per);
endmodule

// File: rtl/clkgen_phase_calc.sv
module clkgen_phase_calc #(
  parameter int CW = 5
) (
  input  logic [CW-1:0] n_i,
  input  logic [1:0]    quad_i,
  output logic [CW-1:0] off_o
);
  localparam int XW = CW + 2;

  logic [XW-1:0] n_x, prod, rnd, off_x;

  assign n_x   = {2'b00, n_i};
  assign prod  = n_x * {{CW{1'b0}}, quad_i};
  assign rnd   = (prod + XW'(2)) >> 2;
  assign off_x = (rnd >= n_x) ? (rnd - n_x) : rnd;
  assign off_o = off_x[CW-1:0];
endmodule

// File: rtl/clkgen_phase_out.sv
module clkgen_phase_out #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] off_i,
  input  logic [CW-1:0] n_i,
  input  logic [CW-1:0] hc_i,
  output logic          q_o
);
  logic [CW-1:0] pos;

  assign pos = (cnt_i >= off_i) ? (cnt_i - off_i) : ((n_i - off_i) + cnt_i);

  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= (pos < hc_i);
  end

  // R10: a high time equal to the period keeps the output high
  a_r10_full_high: assert property (@(posedge clk) disable iff (rst)
    (hc_i == n_i) |=> q_o);
endmodule

// File: rtl/clkgen_top.sv
module clkgen_top
  import clkgen_pkg::*;
#(
  parameter int FW   = 4,
  parameter int NOUT = 3,
  parameter logic [NOUT*PH_W+3*FW-1:0] RST_CFG = 'h62600
) (
  input  logic                      clk_ref,
  input  logic                      rst,
  input  logic [NOUT*PH_W+3*FW-1:0] cfg_word,
  output logic                      cfg_err,
  output logic                      clk_dout,
  output logic                      clk_din,
  output logic                      clk_core
);
  localparam int CW      = FW + 1;
  localparam int PER_LSB = NOUT*PH_W;
  localparam int HI_LSB  = PER_LSB + FW;

  logic [NOUT*PH_W+3*FW-1:0] act_cfg;
  logic [CW-1:0]             cnt, act_n, act_hc;
  logic                      wrap, cfg_ok;
  logic [NOUT-1:0]           ph_q;

  assign act_n  = CW'(act_cfg[PER_LSB +: FW]) + CW'(1);
  assign act_hc = CW'(act_cfg[HI_LSB  +: FW]) + CW'(1);
  assign wrap   = (cnt == act_n - CW'(1));

  clkgen_cfg_check #(.FW(FW), .NOUT(NOUT)) u_check (
    .cfg_i (cfg_word),
    .ok_o  (cfg_ok)
  );

  always_ff @(posedge clk_ref) begin
    if (rst) begin
      cnt     <= '0;
      act_cfg <= RST_CFG;
      cfg_err <= 1'b0;
    end else begin
      cnt     <= wrap ? '0 : cnt + CW'(1);
      cfg_err <= !cfg_ok;
      if (wrap && cfg_ok) act_cfg <= cfg_word;
    end
  end

  for (genvar i = 0; i < NOUT; i++) begin : g_out
    logic [1:0]    quad;
    logic [CW-1:0] off;

    assign quad = phase_quadrant(act_cfg[i*PH_W +: PH_W]);

    clkgen_phase_calc #(.CW(CW)) u_calc (
      .n_i    (act_n),
      .quad_i (quad),
      .off_o  (off)
    );

    clkgen_phase_out #(.CW(CW)) u_out (
      .clk   (clk_ref),
      .rst   (rst),
      .cnt_i (cnt),
      .off_i (off),
      .n_i   (act_n),
      .hc_i  (act_hc),
      .q_o   (ph_q[i])
    );
  end

  assign clk_dout = ph_q[0];
  assign clk_din  = ph_q[1];
  assign clk_core = ph_q[2];

  // R2: the position counter never leaves the active period
  a_r2_cnt_bound: assert property (@(posedge clk_ref) disable iff (rst)
    cnt < act_n);

  // R9: settings never change away from the last cycle of a period
  a_r9_mid_hold: assert property (@(posedge clk_ref) disable iff (rst)
    !wrap |=> $stable(act_cfg));

  // R6: an invalid word at a boundary leaves the settings in force
  a_r6_bad_hold: assert property (@(posedge clk_ref) disable iff (rst)
    (wrap && !cfg_ok) |=> $stable(act_cfg));

  // R8: an invalid word raises the error flag one cycle later
  a_r8_err_follow: assert property (@(posedge clk_ref) disable iff (rst)
    !cfg_ok |=> cfg_err);
endmodule

// File: tb/clkgen_top_bench.sv
module clkgen_top_bench;
  logic        clk_ref = 1'b0;
  logic        rst     = 1'b1;
  logic [20:0] cfg_word;
  logic        cfg_err, clk_dout, clk_din, clk_core;

  localparam logic [20:0] RST_W = 21'h62600;

  always #10 clk_ref = ~clk_ref;

  clkgen_top u_clkgen_top (
    .clk_ref  (clk_ref),
    .rst      (rst),
    .cfg_word (cfg_word),
    .cfg_err  (cfg_err),
    .clk_dout (clk_dout),
    .clk_din  (clk_din),
    .clk_core (clk_core)
  );

  int          n_run  = 0;
  int          n_fail = 0;
  bit          done   = 0;
  int          m_cnt;
  logic [20:0] m_cfg;

  function automatic logic [20:0] mk(int p, int h, int m, int pd, int pi, int pc);
    return {4'(m), 4'(h), 4'(p), 3'(pc), 3'(pi), 3'(pd)};
  endfunction

  function automatic int quad(int c);
    case (c)
      0: return 0;
      1: return 1;
      4: return 2;
      6: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic bit valid(logic [20:0] w);
    int p = int'(w[12:9]);
    int h = int'(w[16:13]);
    int m = int'(w[20:17]);
    return (h <= p) && (m == p) && (quad(int'(w[2:0])) >= 0) &&
           (quad(int'(w[5:3])) >= 0) && (quad(int'(w[8:6])) >= 0);
  endfunction

  function automatic bit exp_out(int slot, int cnt, logic [20:0] w);
    int n   = int'(w[12:9]) + 1;
    int hc  = int'(w[16:13]) + 1;
    int q   = quad(int'(w[slot*3 +: 3]));
    int off = (n*q + 2) / 4;
    if (off >= n) off -= n;
    return ((cnt - off + n) % n) < hc;
  endfunction

  // one reference cycle: predict, advance the model, sample at negedge
  task automatic tick(string tag);
    logic [2:0] e;
    bit         ee;
    for (int i = 0; i < 3; i++) e[i] = exp_out(i, m_cnt, m_cfg);
    ee = !valid(cfg_word);
    if (m_cnt == int'(m_cfg[12:9])) begin
      m_cnt = 0;
      if (valid(cfg_word)) m_cfg = cfg_word;
    end else m_cnt++;
    @(posedge clk_ref);
    @(negedge clk_ref);
    n_run++;
    if ({clk_core, clk_din, clk_dout} !== e || cfg_err !== ee) begin
      n_fail++;
      $display("FAIL %s: core/din/dout=%b err=%b, expected %b err=%b",
               tag, {clk_core, clk_din, clk_dout}, cfg_err, e, ee);
    end
  endtask

  task automatic run(logic [20:0] w, int cycles, string tag);
    cfg_word = w;
    for (int k = 0; k < cycles; k++) tick(tag);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    cfg_word = RST_W;
    repeat (3) @(posedge clk_ref);
    @(negedge clk_ref);
    n_run++;
    if ({clk_core, clk_din, clk_dout, cfg_err} !== 4'b0) begin
      n_fail++;
      $display("FAIL R1: outputs+err=%b, expected 0000",
               {clk_core, clk_din, clk_dout, cfg_err});
    end
    rst   = 1'b0;
    m_cnt = 0;
    m_cfg = RST_W;
    run(RST_W, 8, "R1");
  endtask

  task automatic t_default;
    run(RST_W, 8, "R2");
    run(mk(5, 2, 5, 0, 0, 0), 14, "R2");
  endtask

  task automatic t_phases;
    run(mk(7, 3, 7, 1, 4, 6), 26, "R4");
    run(mk(7, 1, 7, 6, 0, 1), 18, "R4");
  endtask

  task automatic t_round;
    run(mk(4, 1, 4, 1, 4, 6), 22, "R5");
    run(mk(2, 0, 2, 6, 1, 4), 12, "R5");
    run(mk(1, 0, 1, 1, 6, 4), 8, "R5");
  endtask

  task automatic t_bad_high;
    run(mk(5, 2, 5, 0, 1, 0), 12, "R6");
    run(mk(3, 5, 3, 0, 0, 0), 18, "R6");
  endtask

  task automatic t_mirror;
    run(mk(2, 1, 5, 0, 0, 0), 14, "R3");
    run(mk(2, 1, 2, 0, 0, 0), 9, "R3");
  endtask

  task automatic t_code;
    run(mk(5, 2, 5, 2, 0, 0), 12, "R7");
    run(mk(5, 2, 5, 0, 7, 0), 12, "R7");
    run(mk(5, 2, 5, 0, 0, 3), 12, "R7");
  endtask

  task automatic t_err_toggle;
    for (int k = 0; k < 4; k++) begin
      run(mk(4, 1, 4, 0, 0, 0), 1, "R8");
      run(mk(4, 1, 3, 0, 0, 0), 1, "R8");
    end
  endtask

  task automatic t_load;
    run(mk(6, 2, 6, 0, 0, 0), 16, "R9");
    while (m_cnt != 1) tick("R9");
    run(mk(2, 0, 2, 4, 4, 4), 12, "R9");
    run(mk(11, 5, 11, 1, 0, 6), 30, "R9");
  endtask

  task automatic t_extreme;
    run(mk(0, 0, 0, 0, 1, 6), 8, "R10");
    run(mk(15, 15, 15, 1, 4, 6), 40, "R10");
    run(mk(15, 0, 15, 1, 4, 6), 40, "R2");
  endtask

  initial begin
    repeat (100000) @(posedge clk_ref);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    cfg_word = RST_W;
    t_reset();
    t_default();
    t_phases();
    t_round();
    t_bad_high();
    t_mirror();
    t_code();
    t_err_toggle();
    t_load();
    t_extreme();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule